// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs the host side of a 12-bit sampling converter that returns its result on a parallel bus. While enabled, it raises a convert strobe once per sample period. It then waits for the converter to pull its end-of-conversion line low. After that it drives the chip-select and read strobes low, captures the bus and hands the sample on as a one-cycle valid pulse with a 16-bit data word.

The converter line is asynchronous, so it passes through a two-flop synchronizer before the falling edge is detected. The sample period comes from an input. It is raised to a floor equal to the conversion time plus the acquisition time, converted to clock cycles from a clock-frequency parameter. The read window must end a guard time before the next convert edge. When a late end-of-conversion leaves too little room before that edge, the result is dropped and the bus stays released. When end-of-conversion never arrives, a timeout raises an error pulse. A parameter selects the output coding: two's complement for bipolar input ranges or straight binary for the unipolar range.

Top module: `adc_seq`

## Requirements
- R1: During and directly after reset, convst_o is low, cs_n_o and rd_n_o are high, and smp_valid_o and err_o are low.
- R2: When en_i is high, convst_o is high for exactly one cycle per sample period. The spacing between strobes is period_i cycles, raised to a minimum of 418 cycles at default parameters (1470 ns plus 200 ns at 250 MHz, each rounded up to whole cycles).
- R3: The sequencer reacts only to a high-to-low change of eoc_n_i during a conversion. If eoc_n_i is first seen low in cycle n, rd_n_o and cs_n_o go low in cycle n+3.
- R4: cs_n_o and rd_n_o stay low together for RD_HOLD_CYC cycles (3 at default). The bus is captured in the last of those cycles. smp_valid_o is high for one cycle, the cycle after the strobes return high.
- R5: cs_n_o and rd_n_o are high in every cycle where convst_o is high and for the whole conversion, up to the detected end-of-conversion.
- R6: If no end-of-conversion falling edge is detected within 400 cycles of the convert cycle C, err_o is high for one cycle at C+400. No read follows. A falling edge detected in cycle C+399 still leads to a normal read and no error.
- R7: From the falling edge of rd_n_o to the next rising edge of convert there are at least 50 cycles (200 ns). A read that would break this is skipped. No strobes and no valid pulse are produced for that result, and no error is raised.
- R8: A low pulse on eoc_n_i while no conversion is running produces no read, no valid pulse and no error.
- R9: With TWOS_COMP=1, smp_data_o carries the captured 12-bit code with bit 11 copied into bits 15:12. With TWOS_COMP=0, bits 15:12 are zero.
- R10: While en_i is low, no convert strobe is issued. A conversion in progress is abandoned without a read or error, and cs_n_o and rd_n_o stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Run enable for periodic conversion |
| period_i | input | 16 | Requested sample period in clock cycles |
| eoc_n_i | input | 1 | Converter end-of-conversion, active low, asynchronous |
| db_i | input | 12 | Converter parallel result bus |
| convst_o | output | 1 | Convert strobe; its rising edge starts a conversion |
| cs_n_o | output | 1 | Chip-select to converter, active low |
| rd_n_o | output | 1 | Read strobe to converter, active low |
| smp_valid_o | output | 1 | One-cycle pulse marking a new sample |
| smp_data_o | output | 16 | Captured sample in the selected coding |
| err_o | output | 1 | One-cycle pulse on end-of-conversion timeout |

## Verification
Two decisions can land in the same cycle. One is the end of the timeout window. The other is the detected end-of-conversion edge, or that edge together with the guard-room test. The bench places the eoc_n_i fall so that detection lands exactly in the last timeout cycle, and one cycle later. It expects a normal read in the first case and only an error pulse in the second. At the minimum period it places the detection one cycle either side of the last cycle that still leaves 50 cycles of guard room, and checks that exactly one of the two produces a read.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_CONV = 2'd1,
      ST_READ = 2'd2
   } seq_state_t;

   // Round a time in ns up to whole clock cycles.
   function automatic int ns_to_cyc(input int ns, input int clk_mhz);
      return (ns * clk_mhz + 999) / 1000;
   endfunction

endpackage

// File: rtl/adc_eoc_sync.sv
module adc_eoc_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eoc_n_i,
   output logic fall_o
);

   initial begin
      assert (STAGES >= 2) else $error("synchronizer needs at least two stages");
   end

   // sh_q[STAGES-1] is the synchronized level, sh_q[STAGES] its previous value
   logic [STAGES:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= '1;
      else        sh_q <= {sh_q[STAGES-1:0], eoc_n_i};
   end

   assign fall_o = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/adc_period_timer.sv
module adc_period_timer #(
   parameter int PERIOD_W  = 16,
   parameter int MIN_PER   = 418,
   parameter int GUARD_CYC = 50
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic [PERIOD_W-1:0] period_i,
   output logic                tick_o,
   output logic                room_o
);

   localparam logic [PERIOD_W-1:0] MIN_P   = PERIOD_W'(MIN_PER);
   localparam logic [PERIOD_W-1:0] GUARD_P = PERIOD_W'(GUARD_CYC);

   initial begin
      assert (MIN_PER < (1 << PERIOD_W)) else $error("minimum period does not fit the period width");
      assert (MIN_PER > GUARD_CYC) else $error("minimum period must exceed the guard time");
   end

   logic [PERIOD_W-1:0] cnt_q;
   logic [PERIOD_W-1:0] eff_per;

   assign eff_per = (period_i < MIN_P) ? MIN_P : period_i;
   assign tick_o  = en_i && (cnt_q == '0);
   // cycles from now until the next tick cycle
   assign room_o  = (eff_per - cnt_q) >= GUARD_P;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       cnt_q <= '0;
      else if (!en_i)                   cnt_q <= '0;
      else if (cnt_q >= eff_per - 1'b1) cnt_q <= '0;
      else                              cnt_q <= cnt_q + 1'b1;
   end

   AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> !tick_o) else $error("tick lasted two cycles"); // R2

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int DATA_W      = 12,
   parameter int RD_HOLD_CYC = 3,
   parameter int TIMEOUT_CYC = 400
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              tick_i,
   input  logic              fall_i,
   input  logic              room_i,
   input  logic [DATA_W-1:0] db_i,
   output logic              convst_o,
   output logic              cs_n_o,
   output logic              rd_n_o,
   output logic              vld_o,
   output logic              err_o,
   output logic [DATA_W-1:0] raw_o
);

   localparam int TW = $clog2(TIMEOUT_CYC + 1);
   localparam int RW = $clog2(RD_HOLD_CYC + 1);
   localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);
   localparam logic [RW-1:0] RD_LAST  = RW'(RD_HOLD_CYC - 1);

   initial begin
      assert (RD_HOLD_CYC >= 1) else $error("read hold must be at least one cycle");
      assert (TIMEOUT_CYC >= 2) else $error("timeout too short");
   end

   seq_state_t        state_q, nxt;
   logic [TW-1:0]     to_cnt_q;
   logic [RW-1:0]     rd_cnt_q;
   logic              convst_q, err_q, vld_q;
   logic [DATA_W-1:0] raw_q;
   logic              tmo, done;

   assign tmo  = en_i && (state_q == ST_CONV) && !fall_i && (to_cnt_q == TMO_LAST);
   assign done = en_i && (state_q == ST_READ) && (rd_cnt_q == RD_LAST);

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         ST_IDLE: if (tick_i) nxt = ST_CONV;
         ST_CONV: begin
            if (fall_i)                    nxt = room_i ? ST_READ : ST_IDLE;
            else if (to_cnt_q == TMO_LAST) nxt = ST_IDLE;
         end
         ST_READ: if (rd_cnt_q == RD_LAST) nxt = ST_IDLE;
         default: nxt = ST_IDLE;
      endcase
      if (!en_i) nxt = ST_IDLE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         to_cnt_q <= '0;
         rd_cnt_q <= '0;
         convst_q <= 1'b0;
         err_q    <= 1'b0;
         vld_q    <= 1'b0;
         raw_q    <= '0;
      end else begin
         state_q  <= nxt;
         to_cnt_q <= (state_q == ST_CONV) ? to_cnt_q + 1'b1 : '0;
         rd_cnt_q <= (state_q == ST_READ) ? rd_cnt_q + 1'b1 : '0;
         convst_q <= tick_i && (state_q == ST_IDLE);
         err_q    <= tmo;
         vld_q    <= done;
         if (done) raw_q <= db_i;
      end
   end

   assign convst_o = convst_q;
   assign cs_n_o   = (state_q != ST_READ);
   assign rd_n_o   = (state_q != ST_READ);
   assign vld_o    = vld_q;
   assign err_o    = err_q;
   assign raw_o    = raw_q;

   AST_TICK_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_i |-> state_q == ST_IDLE) else $error("period tick while busy"); // R2

   AST_TIMEOUT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      state_q == ST_CONV |-> to_cnt_q < TW'(TIMEOUT_CYC)) else $error("conversion overran timeout"); // R6

   AST_VALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      vld_q |-> $past(state_q == ST_READ)) else $error("valid without read"); // R4

   AST_ERR_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |-> !vld_q && cs_n_o) else $error("error together with read"); // R6

endmodule

// File: rtl/adc_code_fmt.sv
module adc_code_fmt #(
   parameter int DATA_W    = 12,
   parameter int OUT_W     = 16,
   parameter bit TWOS_COMP = 1'b1
) (
   input  logic [DATA_W-1:0] raw_i,
   output logic [OUT_W-1:0]  data_o
);

   localparam int PAD = OUT_W - DATA_W;

   initial begin
      assert (OUT_W > DATA_W) else $error("output must be wider than the converter code");
   end

   generate
      if (TWOS_COMP) begin : g_signed
         assign data_o = {{PAD{raw_i[DATA_W-1]}}, raw_i};
      end else begin : g_unsigned
         assign data_o = {{PAD{1'b0}}, raw_i};
      end
   endgenerate

endmodule

// File: rtl/adc_seq.sv
module adc_seq
   import adc_seq_pkg::*;
#(
   parameter int DATA_W         = 12,
   parameter int OUT_W          = 16,
   parameter int PERIOD_W       = 16,
   parameter int CLK_MHZ        = 250,
   parameter int CONV_NS        = 1470,
   parameter int ACQ_NS         = 200,
   parameter int GUARD_NS       = 200,
   parameter int TMO_MARGIN_CYC = 32,
   parameter int RD_HOLD_CYC    = 3,
   parameter bit TWOS_COMP      = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en_i,
   input  logic [PERIOD_W-1:0] period_i,
   input  logic                eoc_n_i,
   input  logic [DATA_W-1:0]   db_i,
   output logic                convst_o,
   output logic                cs_n_o,
   output logic                rd_n_o,
   output logic                smp_valid_o,
   output logic [OUT_W-1:0]    smp_data_o,
   output logic                err_o
);

   localparam int CONV_CYC    = ns_to_cyc(CONV_NS, CLK_MHZ);
   localparam int ACQ_CYC     = ns_to_cyc(ACQ_NS, CLK_MHZ);
   localparam int GUARD_CYC   = ns_to_cyc(GUARD_NS, CLK_MHZ);
   localparam int MIN_PER     = CONV_CYC + ACQ_CYC;
   localparam int TIMEOUT_CYC = CONV_CYC + TMO_MARGIN_CYC;
   localparam int GW          = $clog2(GUARD_CYC + 1);

   initial begin
      assert (TIMEOUT_CYC + 2 <= MIN_PER) else $error("timeout must end before the next period");
      assert (RD_HOLD_CYC < GUARD_CYC) else $error("read hold must fit in the guard window");
   end

   logic tick, room, fall;
   logic [DATA_W-1:0] raw;

   adc_eoc_sync #(.STAGES(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .eoc_n_i(eoc_n_i), .fall_o(fall)
   );

   adc_period_timer #(
      .PERIOD_W(PERIOD_W), .MIN_PER(MIN_PER), .GUARD_CYC(GUARD_CYC)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .period_i(period_i),
      .tick_o(tick), .room_o(room)
   );

   adc_seq_fsm #(
      .DATA_W(DATA_W), .RD_HOLD_CYC(RD_HOLD_CYC), .TIMEOUT_CYC(TIMEOUT_CYC)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .tick_i(tick), .fall_i(fall),
      .room_i(room), .db_i(db_i), .convst_o(convst_o), .cs_n_o(cs_n_o),
      .rd_n_o(rd_n_o), .vld_o(smp_valid_o), .err_o(err_o), .raw_o(raw)
   );

   adc_code_fmt #(
      .DATA_W(DATA_W), .OUT_W(OUT_W), .TWOS_COMP(TWOS_COMP)
   ) u_fmt (
      .raw_i(raw), .data_o(smp_data_o)
   );

   // distance in cycles since the last falling edge of the read strobe
   logic          rd_prev_q;
   logic [GW-1:0] gap_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_prev_q <= 1'b1;
         gap_q     <= GW'(GUARD_CYC);
      end else begin
         rd_prev_q <= rd_n_o;
         if (rd_prev_q && !rd_n_o)       gap_q <= GW'(1);
         else if (gap_q < GW'(GUARD_CYC)) gap_q <= gap_q + 1'b1;
      end
   end

   AST_BUS_FREE_AT_CONVERT: assert property (@(posedge clk) disable iff (!rst_n)
      convst_o |-> cs_n_o && rd_n_o) else $error("bus driven at convert"); // R5

   AST_READ_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(convst_o) |-> gap_q >= GW'(GUARD_CYC)) else $error("read too close to convert"); // R7

endmodule

// File: tb/adc_seq_tb.sv
module adc_seq_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        en_i = 1'b0;
   logic [15:0] period_i = 16'd1000;
   logic        eoc_n_i = 1'b1;
   logic [11:0] db_i = '0;

   logic        convst_o, cs_n_o, rd_n_o, smp_valid_o, err_o;
   logic [15:0] smp_data_o;
   logic        u_convst, u_cs_n, u_rd_n, u_valid, u_err;
   logic [15:0] u_data;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   adc_seq u_dut (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .period_i(period_i),
      .eoc_n_i(eoc_n_i), .db_i(db_i), .convst_o(convst_o), .cs_n_o(cs_n_o),
      .rd_n_o(rd_n_o), .smp_valid_o(smp_valid_o), .smp_data_o(smp_data_o),
      .err_o(err_o)
   );

   adc_seq #(.TWOS_COMP(1'b0)) u_dut_uni (
      .clk(clk), .rst_n(rst_n), .en_i(en_i), .period_i(period_i),
      .eoc_n_i(eoc_n_i), .db_i(db_i), .convst_o(u_convst), .cs_n_o(u_cs_n),
      .rd_n_o(u_rd_n), .smp_valid_o(u_valid), .smp_data_o(u_data),
      .err_o(u_err)
   );

   task automatic chk(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // advance to the next negedge at which convst_o is high; returns its cycle
   task automatic wait_convst(output int t);
      int lim = 0;
      do begin
         @(negedge clk);
         lim++;
      end while (convst_o !== 1'b1 && lim < 3000);
      chk("R2", "convert strobe seen", (convst_o === 1'b1), 1);
      t = cyc;
   endtask

   // one conversion: eoc low presented j cycles after the convert cycle
   task automatic run_conv(input int j, input logic [11:0] code, input bit exp_read,
                           input bit exp_err, input string tag);
      int t0, rd_first, rd_low, vld_at, err_at, strobe_hi, bus_bad;
      logic [15:0] d_tc, d_sb;
      rd_first = -1; rd_low = 0; vld_at = -1; err_at = -1; bus_bad = 0; strobe_hi = 0;
      d_tc = '0; d_sb = '0;
      wait_convst(t0);
      chk("R5", {tag, " bus free in convert cycle"}, {cs_n_o, rd_n_o}, 2'b11);
      for (int k = 1; k <= j + 12; k++) begin
         @(negedge clk);
         if (convst_o) strobe_hi++;
         if (k < j + 3 && (!cs_n_o || !rd_n_o)) bus_bad++;
         if (!rd_n_o) begin
            if (rd_first < 0) rd_first = k;
            rd_low++;
            if (cs_n_o) bus_bad++;
         end
         if (smp_valid_o) begin
            vld_at = k; d_tc = smp_data_o; d_sb = u_data;
         end
         if (err_o) err_at = k;
         if (k == j) begin eoc_n_i = 1'b0; db_i = code; end
         if (k == j + 3) eoc_n_i = 1'b1;
      end
      chk("R2", {tag, " convert pulse one cycle"}, strobe_hi, 0);
      chk("R5", {tag, " strobes high during conversion"}, bus_bad, 0);
      if (exp_read) begin
         chk("R3", {tag, " read start latency"}, rd_first, j + 3);
         chk("R4", {tag, " read hold length"}, rd_low, 3);
         chk("R4", {tag, " valid cycle"}, vld_at, j + 6);
         chk("R9", {tag, " twos complement data"}, d_tc, {{4{code[11]}}, code});
         chk("R9", {tag, " straight binary data"}, d_sb, {4'h0, code});
      end else begin
         chk("R7", {tag, " no read strobe"}, rd_low, 0);
         chk("R7", {tag, " no valid"}, vld_at, -1);
      end
      if (exp_err) chk("R6", {tag, " timeout error cycle"}, err_at, 400);
      else         chk("R6", {tag, " no error"}, err_at, -1);
   endtask

   task automatic t_reset();
      repeat (4) @(negedge clk);
      chk("R1", "convst in reset", convst_o, 0);
      chk("R1", "cs/rd in reset", {cs_n_o, rd_n_o}, 2'b11);
      chk("R1", "valid/err in reset", {smp_valid_o, err_o}, 2'b00);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "outputs after reset", {convst_o, cs_n_o, rd_n_o, smp_valid_o, err_o}, 5'b01100);
   endtask

   task automatic t_idle_eoc();
      int bad = 0;
      eoc_n_i = 1'b0;
      repeat (4) @(negedge clk);
      eoc_n_i = 1'b1;
      repeat (10) begin
         @(negedge clk);
         if (!rd_n_o || smp_valid_o || err_o || convst_o) bad++;
      end
      chk("R8", "eoc pulse while idle ignored", bad, 0);
   endtask

   task automatic t_period(input logic [15:0] per, input int exp);
      int t1, t2, t3;
      period_i = per;
      wait_convst(t1);
      wait_convst(t2);
      wait_convst(t3);
      chk("R2", $sformatf("strobe spacing for period %0d", per), t3 - t2, exp);
   endtask

   task automatic t_disable();
      int t0, bad = 0;
      wait_convst(t0);
      repeat (10) @(negedge clk);
      en_i = 1'b0;
      eoc_n_i = 1'b0;
      repeat (1500) begin
         @(negedge clk);
         if (convst_o || !cs_n_o || !rd_n_o || smp_valid_o || err_o) bad++;
      end
      eoc_n_i = 1'b1;
      chk("R10", "no activity while disabled", bad, 0);
   endtask

   initial begin
      t_reset();
      t_idle_eoc();
      en_i = 1'b1;
      period_i = 16'd1000;
      run_conv(100, 12'h800, 1, 0, "neg full scale");
      run_conv(150, 12'h7FF, 1, 0, "pos full scale");
      run_conv(120, 12'hFFF, 1, 0, "minus one");
      t_period(16'd1000, 1000);
      t_period(16'd0, 418);
      run_conv(365, 12'h123, 1, 0, "guard edge read");
      run_conv(366, 12'h456, 0, 0, "guard edge skip");
      period_i = 16'd1000;
      run_conv(420, 12'h000, 0, 1, "no eoc timeout");
      run_conv(397, 12'hA5A, 1, 0, "eoc in last timeout cycle");
      run_conv(398, 12'h5A5, 0, 1, "eoc after timeout");
      t_disable();
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         summary();
         $finish;
      end
   end

endmodule